// File: doc/BRIEF.md
# Prescaled 8-bit Overflow Timer

This block is an 8-bit up-counter whose count source is chosen by a 3-bit select field. The source can be one of three kinds. It can be no source at all, so the counter holds. It can be the system clock, either undivided or divided through a free-running prescaler by 8, 64, 256 or 1024. Or it can be single edges of an external input pin, with either the rising or the falling edge chosen. The whole design runs on the system clock. Every source becomes a one-cycle count enable, so no logic runs on a derived clock.

Software reaches four byte-wide registers through a simple write port and a combinational read port: control, count, interrupt mask and overflow flag. When the count wraps from its top value to zero, the block raises an overflow flag. There are two ways to drop that flag. An interrupt controller can send an acknowledge pulse, or software can write a one to the flag bit. The interrupt request is the AND of three terms: the flag, a local mask bit and a global interrupt enable input.

Top module: `tmr8_overflow_timer`

## Requirements
- R1: After synchronous reset, every register (control at address 0, count at 1, mask at 2, flag at 3) reads 0 and irq_req is low.
- R2: Select code 3'b000 in control bits [2:0] stops the counter, and the count holds its value.
- R3: Select code 3'b001 advances the count by one on every system clock.
- R4: Codes 3'b010, 3'b011, 3'b100 and 3'b101 advance the count once per 8, 64, 256 and 1024 system clocks. Each tap fires when the low bits of a free-running 10-bit prescaler are all ones, so any window of N·ratio consecutive clocks gives exactly N increments.
- R5: Code 3'b111 counts rising edges of ext_clk and code 3'b110 counts falling edges. The opposite edge is ignored. The count changes on the third rising clock edge after the pin changes.
- R6: The count register at address 1 can be read and written. A write in the same cycle as a count enable loads the written value and skips the increment.
- R7: When an enabled count takes the value from 8'hFF to 8'h00, the flag (bit 0 of address 3) is set.
- R8: The flag is cleared by an irq_ack pulse or by writing 1 to bit 0 of address 3. Writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag stays set.
- R9: irq_req is high only when global_ie, mask bit 0 of address 2 and the flag are all 1.
- R10: Control bits [7:3] and mask bits [7:1] always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Combinational read data |
| irq_ack | input | 1 | Interrupt serviced pulse, clears the flag |
| global_ie | input | 1 | Global interrupt enable |
| ext_clk | input | 1 | External count input |
| irq_req | output | 1 | Overflow interrupt request |

## Verification
The bench aims at the cycles where two events collide. The first is a count write landing on a count enable; a design that lets the increment win would read back one more than was written. The second is an overflow landing on a write-one clear or on an acknowledge; a design that lets the clear win would lose an interrupt. It measures each prescale ratio over a window that does not depend on prescaler phase, so a wrong tap shows up as a wrong increment total. It also times the external-edge latency and checks that the opposite edge is ignored, which catches a swapped edge polarity or a missing synchronizer stage.

// File: rtl/tmr8_pkg.sv
// Package: shared types and constants for the prescaled overflow timer.
// Assumes an 8-bit register bus with a 2-bit address.
package tmr8_pkg;

    // Clock source select codes; the numeric values are the software encoding.
    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_MASK  = 2'd2;
    localparam logic [1:0] ADDR_FLAG  = 2'd3;

    localparam int PRE_W    = 10;
    localparam int NUM_TAPS = 4;

    // Number of prescaler low bits that must be all ones for tap i.
    function automatic int tap_bits(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
// Module: free-running prescaler that produces one-cycle tick pulses.
// Tap i pulses when the low tap_bits(i) bits of the counter are all ones.
// Assumes the counter is never cleared except by reset.
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int W     = PRE_W,
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NTAPS-1:0] tick
);

    logic [W-1:0] pre_q;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int B = tap_bits(i);
        assign tick[i] = &pre_q[B-1:0];
    end

    // R4: a coarser tap can only fire together with every finer tap.
    for (genvar j = 1; j < NTAPS; j++) begin : g_nest
        a_r4_tap_nesting: assert property (@(posedge clk) disable iff (!rst_n)
            tick[j] |-> tick[j-1]);
    end

endmodule

// File: rtl/tmr8_edge_sync.sv
// Module: synchronizes an asynchronous pin and flags its edges.
// Uses STAGES flops plus one history flop; each edge gives a one-cycle pulse.
// Assumes each pin level is held for longer than one system clock.
module tmr8_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    // Synchronizer chain with one extra stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], pin};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

    // R5: a single sample can never be both a rising and a falling edge.
    a_r5_edge_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    // R5: an edge pulse lasts a single cycle.
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tmr8_count_unit.sv
// Module: count register with load priority and a sticky overflow flag.
// A load beats an increment; an overflow set beats a flag clear.
module tmr8_count_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         flag
);

    localparam logic [W-1:0] TOP = '1;

    logic wrap;

    assign wrap = cnt_en && !load && (count == TOP);

    // Count register: a load wins, otherwise increment on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= load_data;
        else if (cnt_en) count <= count + 1'b1;
    end

    // Overflow flag: set on wrap, else cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load) |=> $stable(count));

    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_data)));

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !load && count == TOP) |=> (flag && count == '0));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(cnt_en && !load && count == TOP)) |=> !flag);

endmodule

// File: rtl/tmr8_overflow_timer.sv
// Module: top of the prescaled 8-bit overflow timer.
// Holds the control and mask registers, picks the count enable from the
// select code, decodes the register bus and forms the interrupt request.
// Assumes ext_clk is asynchronous; the bus read path is combinational.
module tmr8_overflow_timer
    import tmr8_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack,
    input  logic              global_ie,
    input  logic              ext_clk,
    output logic              irq_req
);

    localparam int CS_W = 3;

    clk_sel_e              sel_q;
    logic                  mask_q;
    logic [NUM_TAPS-1:0]   tick;
    logic                  ext_rise;
    logic                  ext_fall;
    logic                  cnt_en;
    logic                  load;
    logic                  flag_clr;
    logic [DATA_W-1:0]     count;
    logic                  flag;

    tmr8_prescaler #(.W(PRE_W), .NTAPS(NUM_TAPS)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tmr8_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    // Control and mask registers; only the implemented bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= CS_STOP;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) sel_q  <= clk_sel_e'(wr_data[CS_W-1:0]);
            if (wr_addr == ADDR_MASK) mask_q <= wr_data[0];
        end
    end

    // Count enable selection from the clock-select code.
    always_comb begin
        case (sel_q)
            CS_DIV1:     cnt_en = 1'b1;
            CS_DIV8:     cnt_en = tick[0];
            CS_DIV64:    cnt_en = tick[1];
            CS_DIV256:   cnt_en = tick[2];
            CS_DIV1024:  cnt_en = tick[3];
            CS_EXT_FALL: cnt_en = ext_fall;
            CS_EXT_RISE: cnt_en = ext_rise;
            default:     cnt_en = 1'b0;
        endcase
    end

    assign load     = wr_en && (wr_addr == ADDR_COUNT);
    assign flag_clr = irq_ack || (wr_en && (wr_addr == ADDR_FLAG) && wr_data[0]);

    tmr8_count_unit #(.W(DATA_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .load     (load),
        .load_data(wr_data),
        .flag_clr (flag_clr),
        .count    (count),
        .flag     (flag)
    );

    // Read multiplexer; unimplemented bits read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL:  rd_data[CS_W-1:0] = sel_q;
            ADDR_COUNT: rd_data           = count;
            ADDR_MASK:  rd_data[0]        = mask_q;
            default:    rd_data[0]        = flag;
        endcase
    end

    assign irq_req = flag && mask_q && global_ie;

    a_r3_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == CS_DIV1 && !load) |=> (count == $past(count) + 1'b1));

    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == CS_STOP && !load) |=> $stable(count));

    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_ie || !flag) |-> !irq_req);

    a_r10_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_CTRL) |-> (rd_data[DATA_W-1:CS_W] == '0));

endmodule

// File: tb/test_tmr8_overflow_timer.sv
// Bench: driver tasks queue expected values; a monitor pops and compares them.
module test_tmr8_overflow_timer;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW         = 8;

    typedef struct {
        string        tag;
        bit           is_irq;
        logic [DW-1:0] exp;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq_ack = 1'b0;
    logic          global_ie = 1'b0;
    logic          ext_clk = 1'b0;
    logic          irq_req;

    item_t sb_q[$];
    event  pushed;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    tmr8_overflow_timer i_tmr8_overflow_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_ack  (irq_ack),
        .global_ie(global_ie),
        .ext_clk  (ext_clk),
        .irq_req  (irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare each queued expectation against the design outputs.
    initial begin
        forever begin
            @(pushed);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [DW-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {{(DW-1){1'b0}}, irq_req} : rd_data;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver helpers; all are called at a falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
        item_t it;
        rd_addr = a;
        #1;
        it.tag = tag; it.is_irq = 1'b0; it.exp = e;
        sb_q.push_back(it);
        -> pushed;
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        #1;
        it.tag = tag; it.is_irq = 1'b1; it.exp = {{(DW-1){1'b0}}, e};
        sb_q.push_back(it);
        -> pushed;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk(2'd0, 8'h00, "R1 ctrl");
        chk(2'd1, 8'h00, "R1 count");
        chk(2'd2, 8'h00, "R1 mask");
        chk(2'd3, 8'h00, "R1 flag");
        chk_irq(1'b0, "R1 irq");

        // R2 stopped counter holds a written value
        wr(2'd1, 8'h5A);
        step(50);
        chk(2'd1, 8'h5A, "R2 hold");

        // R3 and R6: write lands on an enable, then one per clock
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        chk(2'd1, 8'h00, "R6 write wins");
        step(37);
        chk(2'd1, 8'd37, "R3 div1");

        // R4 prescaled rates over phase-independent windows
        wr(2'd0, 8'h02); wr(2'd1, 8'h00); step(64);
        chk(2'd1, 8'd8, "R4 div8");
        wr(2'd0, 8'h03); wr(2'd1, 8'h00); step(640);
        chk(2'd1, 8'd10, "R4 div64");
        wr(2'd0, 8'h04); wr(2'd1, 8'h00); step(512);
        chk(2'd1, 8'd2, "R4 div256");
        wr(2'd0, 8'h05); wr(2'd1, 8'h00); step(1024);
        chk(2'd1, 8'd1, "R4 div1024");

        // R7 overflow sets the flag exactly on the wrap
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFD);
        chk(2'd1, 8'hFD, "R6 load");
        step(2);
        chk(2'd1, 8'hFF, "R7 at top");
        chk(2'd3, 8'h00, "R7 no flag yet");
        step(1);
        chk(2'd1, 8'h00, "R7 wrapped");
        chk(2'd3, 8'h01, "R7 flag set");
        wr(2'd0, 8'h00);

        // R8 writing zero keeps the flag; R9 request gating
        wr(2'd3, 8'h00);
        chk(2'd3, 8'h01, "R8 write zero ignored");
        chk_irq(1'b0, "R9 mask and global off");
        wr(2'd2, 8'h01);
        chk_irq(1'b0, "R9 global off");
        global_ie = 1'b1;
        chk_irq(1'b1, "R9 all set");
        wr(2'd2, 8'h00);
        chk_irq(1'b0, "R9 mask off");
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h01);
        chk(2'd3, 8'h00, "R8 write one clears");
        chk_irq(1'b0, "R9 flag off");

        // R8 set beats a write-one clear in the same cycle
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h01);
        chk(2'd3, 8'h01, "R8 set wins over write");
        wr(2'd0, 8'h00);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        chk(2'd3, 8'h00, "R8 ack clears");
        chk_irq(1'b0, "R9 after ack");

        // R8 set beats an acknowledge in the same cycle
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFF);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        chk(2'd3, 8'h01, "R8 set wins over ack");
        chk_irq(1'b1, "R9 request up");
        wr(2'd0, 8'h00);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;

        // R5 rising-edge counting with its latency
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h07);
        step(3);
        ext_clk = 1'b1;
        step(2);
        chk(2'd1, 8'h00, "R5 latency not yet");
        step(1);
        chk(2'd1, 8'h01, "R5 rise counted");
        ext_clk = 1'b0;
        step(4);
        chk(2'd1, 8'h01, "R5 fall ignored in rise mode");
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1'b1; step(4);
            ext_clk = 1'b0; step(4);
        end
        chk(2'd1, 8'h04, "R5 rise pulses");

        // R5 falling-edge counting
        wr(2'd0, 8'h06);
        ext_clk = 1'b1;
        step(4);
        chk(2'd1, 8'h04, "R5 rise ignored in fall mode");
        ext_clk = 1'b0;
        step(2);
        chk(2'd1, 8'h04, "R5 fall latency not yet");
        step(1);
        chk(2'd1, 8'h05, "R5 fall counted");

        // R10 unimplemented bits read zero
        wr(2'd0, 8'hFF);
        chk(2'd0, 8'h07, "R10 ctrl upper bits");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFE);
        chk(2'd2, 8'h00, "R10 mask upper bits");

        step(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule